// File: doc/BRIEF.md
# Whole-Page Hamming Check Engine

This block watches the data bus of a NAND flash controller and builds a 32-bit Hamming-style check code over a complete page in one pass. The code is built from the position of every 1 bit. A position is the word address in bits [15:4] and the bit index in bits [3:0]. One 16-bit accumulator holds the XOR of these positions. A second 16-bit accumulator holds the XOR of their bitwise complements. The bus is 8 or 16 bits wide. A mode field chooses a data page of 512, 1024, 2048 or 4096 bytes. In the spare-inclusive terms that software often uses, these are 528, 1056, 2112 and 4224 bytes.

When a page is written, software reads the two accumulators once the last data word has passed. It then stores them as the page's 4 code bytes. When a page is read, the stored code bytes must follow the data straight away. The engine compares them with its own result. It then classifies the outcome as clean, a single data bit error, a single bit error inside the stored code, or a multiple error. For a data error it also reports the failing word and bit. Software reaches the engine through a small register port. Software writes a clear bit before each page, which also throws away any address cycles that reached the bus. Software flips the failing bit itself.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, the status register (addr 2) reads 0. The parity register (addr 3) and the complement register (addr 4) read 0, and the mode register (addr 1) reads 0.
- R2: Once the last data word of a page has been taken, the parity register reads the XOR of {word address, bit index} over every 1 bit of the page. This holds until the code words are taken.
- R3: In the same window, the complement register reads the XOR of the bitwise complement of those same positions.
- R4: Mode register bits [1:0] select a data page of 512 << value bytes. After that many bytes, the next words on the bus are taken as the stored code.
- R5: Mode register bit 2 selects the 16-bit bus. In that mode the word address counts 16-bit words, the bit index runs from 0 to 15, and the code arrives as two words: parity first, then complement. In 8-bit mode the address counts bytes, the index runs from 0 to 7, and the code arrives as four bytes: parity low, parity high, complement low, complement high.
- R6: If the stored code matches the page, the status reads 0 after the check.
- R7: A single flipped data bit gives status 1 (bit 0 = error found). The parity register then reads the failing position: word address in [15:4] and bit index in [3:0].
- R8: A single flipped bit in the stored code gives status 3 (bit 1 = error lies in the code).
- R9: Any other mismatch gives status 5 (bit 2 = multiple error). An all-0xFF page with an all-ones code reads as multiple with the parity register at 0xFFFF, so software can detect an erased page.
- R10: Writing 1 to bit 0 of the control register (addr 0) clears both accumulators, the word count, the status and the location. Words seen before the clear have no effect on the code.
- R11: After the check, status and location hold. Further bus words do not change them until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | A data word is on the bus this cycle |
| busData | input | 16 | Bus word; only [7:0] is used in 8-bit mode |
| regAddr | input | 3 | Register select: 0 control, 1 mode, 2 status, 3 parity/location, 4 complement |
| regWrEn | input | 1 | Write strobe for the control and mode registers |
| cfgWrData | input | 3 | Write data: bit 0 clear (control); bits [1:0] size and bit 2 wide bus (mode) |
| regRdData | output | 16 | Read data for regAddr, combinational |

## Verification
A word counter that ends one word early or late moves the boundary between data and code. This shows up at once as a wrong parity value on a write, and as a multiple-error status on a read of a clean page. An accumulator that misses a bit position shows up as a wrong location or a wrong outcome class. This appears two cycles after the last code word. A status or location register that fails to hold is caught when words are sent after the check and the registers are read back. The bench computes every code value from the page bytes by arithmetic. It sweeps all four page sizes, both bus widths, and single flips in both data and code.

// File: rtl/nand_page_ecc_pkg.sv
package nand_page_ecc_pkg;
  parameter int BUS_W     = 16;
  parameter int ADDR_W    = 12;
  parameter int IDX_W     = 4;
  parameter int POS_W     = ADDR_W + IDX_W;
  parameter int CNT_W     = ADDR_W + 1;
  parameter int BASE_SIZE = 512;
  parameter int CFG_W     = 3;
  parameter int REG_W     = 16;

  typedef enum logic [1:0] {PH_DATA, PH_CODE, PH_EVAL, PH_DONE} phase_t;

  typedef struct packed {
    logic              clear;
    logic              accum;
    logic              snap;
    logic              capture;
    logic              finish;
    logic              wide;
    logic [1:0]        codeIdx;
    logic [ADDR_W-1:0] wordAddr;
  } strobe_t;
endpackage

// File: rtl/nand_page_ecc_ctrl.sv
module nand_page_ecc_ctrl
  import nand_page_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic [2:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output strobe_t          strb,
  output logic [1:0]       sizeSel,
  output logic             wideBus
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;

  phase_t           phase;
  logic [CNT_W-1:0] wordCnt;
  logic [1:0]       codeIdx;
  logic [CNT_W-1:0] dataLast;
  logic [1:0]       codeLast;
  logic             clearReq;

  always_comb begin
    dataLast = CNT_W'((BASE_SIZE << sizeSel) >> wideBus) - CNT_W'(1);
    codeLast = wideBus ? 2'd1 : 2'd3;
    clearReq = regWrEn && (regAddr == A_CTRL) && cfgWrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeSel <= 2'd0;
      wideBus <= 1'b0;
    end else if (regWrEn && regAddr == A_MODE) begin
      sizeSel <= cfgWrData[1:0];
      wideBus <= cfgWrData[2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_DATA;
      wordCnt <= '0;
      codeIdx <= '0;
    end else if (clearReq) begin
      phase   <= PH_DATA;
      wordCnt <= '0;
      codeIdx <= '0;
    end else begin
      unique case (phase)
        PH_DATA: if (busValid) begin
          if (wordCnt == dataLast) begin
            phase   <= PH_CODE;
            codeIdx <= '0;
          end else begin
            wordCnt <= wordCnt + CNT_W'(1);
          end
        end
        PH_CODE: if (busValid) begin
          if (codeIdx == codeLast) phase <= PH_EVAL;
          else codeIdx <= codeIdx + 2'd1;
        end
        PH_EVAL: phase <= PH_DONE;
        PH_DONE: phase <= PH_DONE;
        default: phase <= PH_DATA;
      endcase
    end
  end

  always_comb begin
    strb.clear    = clearReq;
    strb.accum    = busValid && (phase == PH_DATA) && !clearReq;
    strb.snap     = strb.accum && (wordCnt == dataLast);
    strb.capture  = busValid && (phase == PH_CODE) && !clearReq;
    strb.finish   = (phase == PH_EVAL) && !clearReq;
    strb.wide     = wideBus;
    strb.codeIdx  = codeIdx;
    strb.wordAddr = wordCnt[ADDR_W-1:0];
  end

  // R4: the data counter never runs past the selected page length
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (wordCnt <= dataLast));
  // R10: a clear returns the sequencer to the start of a page
  a_r10_clear_restart: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (phase == PH_DATA && wordCnt == '0));
  // R11: once checked, the page stays checked until cleared
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE && !clearReq) |=> (phase == PH_DONE));
endmodule

// File: rtl/nand_page_ecc_dp.sv
module nand_page_ecc_dp
  import nand_page_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [BUS_W-1:0] busData,
  input  logic [2:0]       regAddr,
  input  logic [1:0]       sizeSel,
  input  logic             wideBus,
  output logic [REG_W-1:0] regRdData
);
  localparam int CODE_W = 2 * POS_W;

  logic [POS_W-1:0]  accP, accN, codeP, codeN, locReg;
  logic [CODE_W-1:0] stored;
  logic [2:0]        status;
  logic              checked;

  logic [IDX_W-1:0]  idxXor;
  logic              onesOdd;
  logic [POS_W-1:0]  addP, addN;
  logic [POS_W-1:0]  syndP, syndN;
  logic [2:0]        verdict;

  // per-word contribution: XOR of set-bit positions and of their complements
  always_comb begin
    idxXor  = '0;
    onesOdd = 1'b0;
    for (int i = 0; i < BUS_W; i++) begin
      if (busData[i] && (strb.wide || i < 8)) begin
        idxXor  = idxXor ^ IDX_W'(i);
        onesOdd = ~onesOdd;
      end
    end
    addP = {onesOdd ? strb.wordAddr : {ADDR_W{1'b0}}, idxXor};
    addN = addP ^ {POS_W{onesOdd}};
  end

  always_comb begin
    syndP = codeP ^ stored[POS_W-1:0];
    syndN = codeN ^ stored[CODE_W-1:POS_W];
    if ({syndN, syndP} == '0)              verdict = 3'b000;
    else if (syndP == ~syndN)              verdict = 3'b001;
    else if ($countones({syndN, syndP}) == 1) verdict = 3'b011;
    else                                   verdict = 3'b101;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accP <= '0; accN <= '0; codeP <= '0; codeN <= '0;
      stored <= '0; status <= '0; locReg <= '0; checked <= 1'b0;
    end else if (strb.clear) begin
      accP <= '0; accN <= '0; codeP <= '0; codeN <= '0;
      stored <= '0; status <= '0; locReg <= '0; checked <= 1'b0;
    end else begin
      if (strb.accum) begin
        accP <= accP ^ addP;
        accN <= accN ^ addN;
      end
      if (strb.snap) begin
        codeP <= accP ^ addP;
        codeN <= accN ^ addN;
      end
      if (strb.capture) begin
        if (strb.wide) begin
          if (strb.codeIdx[0]) stored[CODE_W-1:POS_W] <= busData;
          else                 stored[POS_W-1:0]      <= busData;
        end else begin
          unique case (strb.codeIdx)
            2'd0: stored[7:0]   <= busData[7:0];
            2'd1: stored[15:8]  <= busData[7:0];
            2'd2: stored[23:16] <= busData[7:0];
            default: stored[31:24] <= busData[7:0];
          endcase
        end
      end
      if (strb.finish) begin
        status  <= verdict;
        locReg  <= syndP;
        checked <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      3'd1:    regRdData = REG_W'({wideBus, sizeSel});
      3'd2:    regRdData = REG_W'(status);
      3'd3:    regRdData = checked ? locReg : codeP;
      3'd4:    regRdData = codeN;
      default: regRdData = '0;
    endcase
  end

  // R3: the complement accumulator always equals the parity one or its inverse
  a_r3_complement_pair: assert property (@(posedge clk) disable iff (!rstN)
    (accN == accP) || (accN == ~accP));
  // R9: code-error and multiple-error flags never both set
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(status[2:1]));
  // R7: any detailed flag implies the error-found flag
  a_r7_any_flag: assert property (@(posedge clk) disable iff (!rstN)
    (status[2:1] != 2'b00) |-> status[0]);
  // R11: status and location hold after the check
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (checked && !strb.clear) |=> ($stable(status) && $stable(locReg)));
  // R10: clear empties both accumulators
  a_r10_clear_acc: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (accP == '0 && accN == '0 && status == '0));
endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_page_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic [BUS_W-1:0] busData,
  input  logic [2:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] regRdData
);
  strobe_t    strb;
  logic [1:0] sizeSel;
  logic       wideBus;

  nand_page_ecc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .regAddr(regAddr),
    .regWrEn(regWrEn), .cfgWrData(cfgWrData), .strb(strb),
    .sizeSel(sizeSel), .wideBus(wideBus)
  );

  nand_page_ecc_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busData(busData),
    .regAddr(regAddr), .sizeSel(sizeSel), .wideBus(wideBus),
    .regRdData(regRdData)
  );
endmodule

// File: tb/nand_page_ecc_test.sv
module nand_page_ecc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [15:0] busData = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  cfgWrData = '0;
  logic [15:0] regRdData;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] pageMem [4096];

  always #4 clk = ~clk;

  nand_page_ecc uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busData(busData),
    .regAddr(regAddr), .regWrEn(regWrEn), .cfgWrData(cfgWrData),
    .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [2:0] d);
    @(negedge clk);
    regAddr = a; cfgWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk);
    busValid = 1'b1; busData = w;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    busValid = 1'b0; busData = '0;
    repeat (n) @(negedge clk);
  endtask

  // expected code by arithmetic over the page bytes
  function automatic logic [31:0] calcCode(input int nBytes, input bit wide);
    logic [15:0] p = '0, n = '0, pos;
    for (int b = 0; b < nBytes; b++)
      for (int i = 0; i < 8; i++)
        if (pageMem[b][i]) begin
          pos = wide ? 16'(((b / 2) << 4) + (b % 2) * 8 + i) : 16'((b << 4) + i);
          p ^= pos; n ^= ~pos;
        end
    return {n, p};
  endfunction

  task automatic sendPage(input int nBytes, input bit wide);
    if (wide) for (int k = 0; k < nBytes / 2; k++) sendWord({pageMem[2*k+1], pageMem[2*k]});
    else      for (int k = 0; k < nBytes; k++)     sendWord({8'h00, pageMem[k]});
  endtask

  task automatic sendCode(input logic [31:0] c, input bit wide);
    if (wide) begin sendWord(c[15:0]); sendWord(c[31:16]); end
    else for (int k = 0; k < 4; k++) sendWord({8'h00, c[8*k +: 8]});
  endtask

  function automatic void fillPage(input int seed);
    for (int b = 0; b < 4096; b++) pageMem[b] = 8'((b * 37 + seed * 11 + (b >> 3)) ^ (b >> 5));
  endfunction

  // write pass: check both parity registers after data; returns the code
  task automatic writePass(input string req, input int sz, input bit wide, output logic [31:0] code);
    logic [15:0] v;
    int nBytes = 512 << sz;
    writeReg(3'd1, {wide, 2'(sz)});
    writeReg(3'd0, 3'd1);
    sendPage(nBytes, wide);
    idle(1);
    code = calcCode(nBytes, wide);
    readReg(3'd3, v); check({req, " R2 parity"}, v, code[15:0]);
    readReg(3'd4, v); check({req, " R3 complement"}, v, code[31:16]);
  endtask

  task automatic readPass(input int sz, input bit wide, input logic [31:0] code,
                          output logic [15:0] st, output logic [15:0] loc);
    writeReg(3'd1, {wide, 2'(sz)});
    writeReg(3'd0, 3'd1);
    sendPage(512 << sz, wide);
    sendCode(code, wide);
    idle(3);
    readReg(3'd2, st);
    readReg(3'd3, loc);
  endtask

  initial begin
    logic [15:0] v, st, loc;
    logic [31:0] code;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readReg(3'd2, v); check("R1 status", v, 16'h0);
    readReg(3'd3, v); check("R1 parity", v, 16'h0);
    readReg(3'd4, v); check("R1 complement", v, 16'h0);
    readReg(3'd1, v); check("R1 mode", v, 16'h0);

    // R4/R5: all sizes, both widths, clean read gives status 0 (R6)
    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 4; sz++) begin
        fillPage(sz + 4 * w);
        writePass(w ? "R5" : "R4", sz, bit'(w), code);
        readPass(sz, bit'(w), code, st, loc);
        check("R6 clean status", st, 16'h0);
      end

    // R7 single data flips, 8-bit 512
    for (int t = 0; t < 6; t++) begin
      int b = t * 97 + 3; int i = t % 8;
      fillPage(20 + t);
      code = calcCode(512, 1'b0);
      pageMem[b][i] = ~pageMem[b][i];
      readPass(0, 1'b0, code, st, loc);
      check("R7 status", st, 16'h1);
      check("R7 location", loc, 16'((b << 4) + i));
    end
    // R7/R5 single data flip, 16-bit 1024, high byte
    fillPage(40);
    code = calcCode(1024, 1'b1);
    pageMem[201][5] = ~pageMem[201][5];
    readPass(1, 1'b1, code, st, loc);
    check("R7 wide status", st, 16'h1);
    check("R5 wide location", loc, 16'((100 << 4) + 13));

    // R8 code flips in every code byte
    for (int k = 0; k < 4; k++) begin
      fillPage(50 + k);
      code = calcCode(512, 1'b0);
      code[8*k + k] = ~code[8*k + k];
      readPass(0, 1'b0, code, st, loc);
      check("R8 code error", st, 16'h3);
    end

    // R9 double data flip
    fillPage(60);
    code = calcCode(2048, 1'b0);
    pageMem[10][1] = ~pageMem[10][1];
    pageMem[777][6] = ~pageMem[777][6];
    readPass(2, 1'b0, code, st, loc);
    check("R9 multiple", st, 16'h5);

    // R9 erased page, both widths
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 4096; b++) pageMem[b] = 8'hFF;
      readPass(0, bit'(w), 32'hFFFF_FFFF, st, loc);
      check("R9 erased status", st, 16'h5);
      check("R9 erased location", loc, 16'hFFFF);
    end

    // R11: words after the check do not disturb status/location
    fillPage(70);
    code = calcCode(512, 1'b0);
    pageMem[44][2] = ~pageMem[44][2];
    readPass(0, 1'b0, code, st, loc);
    sendWord(16'h00A5); sendWord(16'h0013); sendWord(16'h00FF);
    idle(2);
    readReg(3'd2, v); check("R11 status held", v, 16'h1);
    readReg(3'd3, v); check("R11 location held", v, 16'((44 << 4) + 2));

    // R10: junk address cycles discarded by the clear
    fillPage(80);
    writeReg(3'd1, 3'd0);
    sendWord(16'h0070); sendWord(16'h0012); sendWord(16'h0034);
    idle(1);
    writeReg(3'd0, 3'd1);
    readReg(3'd3, v); check("R10 cleared parity", v, 16'h0);
    sendPage(512, 1'b0);
    idle(1);
    code = calcCode(512, 1'b0);
    readReg(3'd3, v); check("R10 parity after clear", v, code[15:0]);
    readReg(3'd4, v); check("R10 complement after clear", v, code[31:16]);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule